// File: doc/BRIEF.md
# Pause Frame Receive Detector and Transmit Inhibit Timer

This block watches the receive byte stream of an Ethernet MAC and picks out MAC control PAUSE frames. When one arrives intact, the block raises a transmit-inhibit output for the pause time the frame carries. It also gives a one-cycle pulse for every PAUSE frame it accepts. Frame reception, CRC checking and the transmitter are handled elsewhere. The block sees only a byte strobe with start-of-frame and end-of-frame marks, plus a CRC verdict on the last byte.

A frame is accepted as a PAUSE frame if it passes four tests. Its destination must be the reserved flow-control multicast address, or the station's own address when unicast detection is switched on. Its type field must mark a MAC control frame. Its opcode must mark PAUSE. Its CRC must be good. The 16-bit pause time in the frame is counted down in slot times of 512 bit times, using a bit-time tick from the transmit clock domain. A later PAUSE frame replaces whatever time remains. A pause time of zero ends an inhibit at once.

The parser is a state machine over the frame header. Its states are S_IDLE (no frame open), S_DEST (destination bytes), S_SRC (source bytes), S_TYPE (type field), S_OPCODE (opcode), S_QUANTA (pause time), S_TAIL (padding up to end of frame) and S_DROP (frame rejected, wait for end). A start-of-frame byte in any state moves the parser to S_DEST. A complete destination match moves it from S_DEST to S_SRC; a mismatch moves it to S_DROP. After six source bytes it moves to S_TYPE. A matching type moves it to S_OPCODE and a matching opcode moves it to S_QUANTA; any mismatch moves it to S_DROP. The second pause-time byte moves it to S_TAIL. An end-of-frame byte in any state returns the parser to S_IDLE. The timer is a second state machine with states T_IDLE and T_HOLD. A load with a nonzero time moves it from T_IDLE to T_HOLD. Three events return it from T_HOLD to T_IDLE: the last slot of the last quantum expires, a zero-time load arrives, or the enable is cleared.

Top module: `pause_rx_inhibit`

## Requirements
- R1: While `rx_fc_en` is low, `tx_inhibit` is low, no `pause_seen` pulse is produced, and any running pause is cancelled. Setting `rx_fc_en` again does not restore the cancelled pause.
- R2: A frame whose destination bytes 0..5 are 01-80-C2-00-00-01, in order of arrival, is accepted when the other PAUSE conditions hold. This does not depend on `ucast_det_en`.
- R3: A frame whose destination equals `station_addr` is accepted only while `ucast_det_en` is high. Bits [47:40] of `station_addr` are compared with the first destination byte. When `ucast_det_en` is low, such a frame leaves the outputs unchanged.
- R4: A frame qualifies only if bytes 12..13 hold 0x88, 0x08 and bytes 14..15 hold 0x00, 0x01. Any other value leaves the outputs unchanged.
- R5: The pause time is bytes 16..17, most significant byte first. After acceptance, `tx_inhibit` stays high for exactly pause_time x 512 cycles of `bit_tick`.
- R6: A frame is acted on only if `rx_crc_ok` is high on its end-of-frame byte. A frame with a bad CRC does not change `tx_inhibit`.
- R7: A PAUSE frame that arrives while an inhibit is running restarts the count from its own pause time.
- R8: An accepted PAUSE frame with pause time zero drops `tx_inhibit` in the cycle after its end-of-frame byte.
- R9: `tx_inhibit` falls in the same cycle in which the remaining count reaches zero.
- R10: `pause_seen` is high for exactly one cycle, the cycle after the end-of-frame byte of an accepted frame. In that same cycle `tx_inhibit` rises if the pause time is nonzero.
- R11: A frame that ends before its 18th byte is ignored. A start-of-frame byte restarts parsing from the first destination byte, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_crc_ok | input | 1 | CRC verdict, valid on the last byte |
| station_addr | input | 48 | Own station address, first byte in [47:40] |
| rx_fc_en | input | 1 | Enables PAUSE decoding and the inhibit |
| ucast_det_en | input | 1 | Also accept PAUSE frames sent to `station_addr` |
| bit_tick | input | 1 | One pulse per bit time |
| tx_inhibit | output | 1 | Hold off the local transmitter |
| pause_seen | output | 1 | One-cycle pulse per accepted PAUSE frame |

## Verification
The bench targets these corner cases:
- A bad-CRC frame and a zero-time frame arriving in the middle of a running pause. A design that loaded the timer before checking the CRC would cut the pause short. A design that ignored zero would keep the transmitter held.
- Reloading with a shorter time during a pause. A design that kept the larger of the two values would run too long.
- Exact pause length, counted in cycles with a tick on every clock and with a slower tick. An off-by-one in the slot counter would stretch or shorten the inhibit by a slot.
- Unicast frames with detection off, wrong type or opcode, frames cut short, and a start-of-frame in the middle of a frame. A parser that did not reset its field position would accept such frames or miss the following valid one.
- Clearing the enable during a pause. A design that only masked the output would resume the old pause when the enable returned.

// File: rtl/pause_rx_pkg.sv
package pause_rx_pkg;

    localparam logic [47:0] PAUSE_GROUP_ADDR = 48'h0180_C200_0001;
    localparam logic [15:0] CTRL_ETHERTYPE   = 16'h8808;
    localparam logic [15:0] PAUSE_OPCODE     = 16'h0001;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEST,
        S_SRC,
        S_TYPE,
        S_OPCODE,
        S_QUANTA,
        S_TAIL,
        S_DROP
    } parse_state_e;

    typedef enum logic {
        T_IDLE,
        T_HOLD
    } timer_state_e;

    function automatic logic [7:0] addr_byte(input logic [47:0] addr, input logic [2:0] idx);
        logic [47:0] shifted;
        shifted = addr << {idx, 3'b000};
        return shifted[47:40];
    endfunction

endpackage

// File: rtl/pause_frame_parser.sv
module pause_frame_parser
    import pause_rx_pkg::*;
#(
    parameter int QUANTA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic [7:0]          rx_data,
    input  logic                rx_sof,
    input  logic                rx_eof,
    input  logic                rx_crc_ok,
    input  logic [47:0]         station_addr,
    input  logic                ucast_det_en,
    output logic                frame_hit,
    output logic [QUANTA_W-1:0] hit_quanta
);

    localparam int FIELD_CNT_W = 3;
    localparam logic [FIELD_CNT_W-1:0] ADDR_LAST = FIELD_CNT_W'(5);

    parse_state_e            state, state_nx;
    logic [FIELD_CNT_W-1:0]  pos, pos_nx;
    logic                    grp_ok, grp_ok_nx;
    logic                    own_ok, own_ok_nx;
    logic [7:0]              q_hi, q_hi_nx;
    logic [QUANTA_W-1:0]     q_val, q_val_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            pos    <= '0;
            grp_ok <= 1'b0;
            own_ok <= 1'b0;
            q_hi   <= '0;
            q_val  <= '0;
        end else begin
            state  <= state_nx;
            pos    <= pos_nx;
            grp_ok <= grp_ok_nx;
            own_ok <= own_ok_nx;
            q_hi   <= q_hi_nx;
            q_val  <= q_val_nx;
        end
    end

    always_comb begin
        state_nx   = state;
        pos_nx     = pos;
        grp_ok_nx  = grp_ok;
        own_ok_nx  = own_ok;
        q_hi_nx    = q_hi;
        q_val_nx   = q_val;
        frame_hit  = 1'b0;
        hit_quanta = '0;
        if (rx_valid) begin
            if (rx_sof) begin
                state_nx  = S_DEST;
                pos_nx    = FIELD_CNT_W'(1);
                grp_ok_nx = (rx_data == addr_byte(PAUSE_GROUP_ADDR, 3'd0));
                own_ok_nx = (rx_data == addr_byte(station_addr, 3'd0));
            end else begin
                unique case (state)
                    S_IDLE, S_DROP: begin
                        state_nx = state;
                    end
                    S_DEST: begin
                        grp_ok_nx = grp_ok && (rx_data == addr_byte(PAUSE_GROUP_ADDR, pos));
                        own_ok_nx = own_ok && (rx_data == addr_byte(station_addr, pos));
                        if (pos == ADDR_LAST) begin
                            pos_nx   = '0;
                            state_nx = (grp_ok_nx || (own_ok_nx && ucast_det_en)) ? S_SRC : S_DROP;
                        end else begin
                            pos_nx = pos + 1'b1;
                        end
                    end
                    S_SRC: begin
                        if (pos == ADDR_LAST) begin
                            pos_nx   = '0;
                            state_nx = S_TYPE;
                        end else begin
                            pos_nx = pos + 1'b1;
                        end
                    end
                    S_TYPE: begin
                        if (pos == '0) begin
                            pos_nx   = FIELD_CNT_W'(1);
                            state_nx = (rx_data == CTRL_ETHERTYPE[15:8]) ? S_TYPE : S_DROP;
                        end else begin
                            pos_nx   = '0;
                            state_nx = (rx_data == CTRL_ETHERTYPE[7:0]) ? S_OPCODE : S_DROP;
                        end
                    end
                    S_OPCODE: begin
                        if (pos == '0) begin
                            pos_nx   = FIELD_CNT_W'(1);
                            state_nx = (rx_data == PAUSE_OPCODE[15:8]) ? S_OPCODE : S_DROP;
                        end else begin
                            pos_nx   = '0;
                            state_nx = (rx_data == PAUSE_OPCODE[7:0]) ? S_QUANTA : S_DROP;
                        end
                    end
                    S_QUANTA: begin
                        if (pos == '0) begin
                            pos_nx  = FIELD_CNT_W'(1);
                            q_hi_nx = rx_data;
                        end else begin
                            pos_nx   = '0;
                            q_val_nx = QUANTA_W'({q_hi, rx_data});
                            state_nx = S_TAIL;
                            if (rx_eof && rx_crc_ok) begin
                                frame_hit  = 1'b1;
                                hit_quanta = q_val_nx;
                            end
                        end
                    end
                    S_TAIL: begin
                        if (rx_eof && rx_crc_ok) begin
                            frame_hit  = 1'b1;
                            hit_quanta = q_val;
                        end
                    end
                endcase
            end
            if (rx_eof) begin
                state_nx = S_IDLE;
            end
        end
    end

endmodule

// File: rtl/pause_slot_timer.sv
module pause_slot_timer
    import pause_rx_pkg::*;
#(
    parameter int SLOT_BITS = 512,
    parameter int QUANTA_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                load,
    input  logic [QUANTA_W-1:0] load_val,
    input  logic                bit_tick,
    output logic                busy,
    output logic [QUANTA_W-1:0] remaining
);

    localparam int SLOT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_BITS - 1);

    timer_state_e        state, state_nx;
    logic [SLOT_W-1:0]   slot_cnt;
    logic [QUANTA_W-1:0] rem_q;
    logic                slot_end;

    assign slot_end = bit_tick && (slot_cnt == SLOT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= T_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (clr) begin
            state_nx = T_IDLE;
        end else if (load) begin
            state_nx = (load_val != '0) ? T_HOLD : T_IDLE;
        end else begin
            unique case (state)
                T_IDLE: state_nx = T_IDLE;
                T_HOLD: begin
                    if (slot_end && rem_q == QUANTA_W'(1)) begin
                        state_nx = T_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            slot_cnt <= '0;
            rem_q    <= '0;
        end else if (load) begin
            slot_cnt <= '0;
            rem_q    <= load_val;
        end else if (state == T_HOLD && bit_tick) begin
            if (slot_end) begin
                slot_cnt <= '0;
                rem_q    <= rem_q - 1'b1;
            end else begin
                slot_cnt <= slot_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        busy      = (state == T_HOLD);
        remaining = rem_q;
    end

endmodule

// File: rtl/pause_rx_inhibit.sv
module pause_rx_inhibit
    import pause_rx_pkg::*;
#(
    parameter int SLOT_BITS = 512,
    parameter int QUANTA_W  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_crc_ok,
    input  logic [47:0] station_addr,
    input  logic        rx_fc_en,
    input  logic        ucast_det_en,
    input  logic        bit_tick,
    output logic        tx_inhibit,
    output logic        pause_seen
);

    logic                frame_hit;
    logic [QUANTA_W-1:0] hit_quanta;
    logic                timer_busy;
    logic [QUANTA_W-1:0] timer_rem;
    logic                seen_q;
    logic                accept;

    pause_frame_parser #(
        .QUANTA_W (QUANTA_W)
    ) u_parser (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_crc_ok    (rx_crc_ok),
        .station_addr (station_addr),
        .ucast_det_en (ucast_det_en),
        .frame_hit    (frame_hit),
        .hit_quanta   (hit_quanta)
    );

    assign accept = frame_hit && rx_fc_en;

    pause_slot_timer #(
        .SLOT_BITS (SLOT_BITS),
        .QUANTA_W  (QUANTA_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!rx_fc_en),
        .load      (accept),
        .load_val  (hit_quanta),
        .bit_tick  (bit_tick),
        .busy      (timer_busy),
        .remaining (timer_rem)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= accept;
        end
    end

    always_comb begin
        tx_inhibit = timer_busy && rx_fc_en;
        pause_seen = seen_q;
    end

endmodule

// File: rtl/pause_rx_inhibit_chk.sv
module pause_rx_inhibit_chk #(
    parameter int QUANTA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_valid,
    input logic                rx_eof,
    input logic                rx_crc_ok,
    input logic                rx_fc_en,
    input logic                tx_inhibit,
    input logic                pause_seen,
    input logic                frame_hit,
    input logic [QUANTA_W-1:0] hit_quanta,
    input logic [QUANTA_W-1:0] timer_rem
);

    assert_off_no_inhibit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_fc_en |-> !tx_inhibit);

    assert_seen_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pause_seen |-> $past(rx_fc_en));

    assert_seen_after_good_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pause_seen |-> $past(rx_valid && rx_eof && rx_crc_ok));

    assert_rise_only_on_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_inhibit) |-> pause_seen);

    assert_zero_quanta_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_hit && rx_fc_en && hit_quanta == '0) |=> !tx_inhibit);

    assert_load_raises_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_hit && rx_fc_en && hit_quanta != '0) |=> (tx_inhibit || !rx_fc_en));

    assert_pulse_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pause_seen |=> (!pause_seen || $past(frame_hit && rx_fc_en)));

    assert_inhibit_tracks_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fc_en |-> (tx_inhibit == (timer_rem != '0)));

endmodule

bind pause_rx_inhibit pause_rx_inhibit_chk #(
    .QUANTA_W (QUANTA_W)
) u_pause_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_eof     (rx_eof),
    .rx_crc_ok  (rx_crc_ok),
    .rx_fc_en   (rx_fc_en),
    .tx_inhibit (tx_inhibit),
    .pause_seen (pause_seen),
    .frame_hit  (frame_hit),
    .hit_quanta (hit_quanta),
    .timer_rem  (timer_rem)
);

// File: tb/test_pause_rx_inhibit.sv
module test_pause_rx_inhibit;

    localparam logic [47:0] GROUP   = 48'h0180_C200_0001;
    localparam logic [47:0] STATION = 48'h0211_2233_4455;
    localparam int          SLOT    = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic        rx_crc_ok = 1'b0;
    logic [47:0] station_addr = STATION;
    logic        rx_fc_en = 1'b1;
    logic        ucast_det_en = 1'b0;
    logic        bit_tick = 1'b0;
    logic        tx_inhibit;
    logic        pause_seen;

    int    checks = 0;
    int    fails = 0;
    int    tick_div = 1;
    int    cyc = 0;
    bit    bench_hit = 1'b0;
    int    bench_q = 0;
    int    left = 0;
    bit    exp_seen = 1'b0;
    bit    cmp_on = 1'b0;
    string cur_req = "R10";

    always #10 clk = ~clk;

    pause_rx_inhibit i_pause_rx_inhibit (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_crc_ok    (rx_crc_ok),
        .station_addr (station_addr),
        .rx_fc_en     (rx_fc_en),
        .ucast_det_en (ucast_det_en),
        .bit_tick     (bit_tick),
        .tx_inhibit   (tx_inhibit),
        .pause_seen   (pause_seen)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        bit_tick = ((cyc % tick_div) == 0);
    end

    // Behavioural reference: remaining bit ticks of the current pause.
    always @(posedge clk) begin
        if (!rst_n) begin
            left = 0;
            exp_seen = 1'b0;
        end else begin
            exp_seen = 1'b0;
            if (!rx_fc_en) begin
                left = 0;
            end else if (rx_valid && rx_eof && bench_hit) begin
                left = bench_q * SLOT;
                exp_seen = 1'b1;
            end else if (bit_tick && left > 0) begin
                left = left - 1;
            end
        end
    end

    always @(posedge clk) begin
        #5;
        if (cmp_on) begin
            checks++;
            if (tx_inhibit !== ((left > 0) && rx_fc_en)) begin
                fails++;
                $display("FAIL %s per-cycle tx_inhibit actual=%0b expected=%0b", cur_req,
                         tx_inhibit, (left > 0) && rx_fc_en);
            end
            checks++;
            if (pause_seen !== exp_seen) begin
                fails++;
                $display("FAIL %s per-cycle pause_seen actual=%0b expected=%0b", cur_req,
                         pause_seen, exp_seen);
            end
        end
    end

    task automatic check_val(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_frame(input string req, input logic [47:0] da, input logic [15:0] ty,
                              input logic [15:0] op, input logic [15:0] q, input int len,
                              input bit crc, input bit with_eof, input bit gaps);
        logic [7:0] b[$];
        bit         exp;
        for (int i = 0; i < 6; i++) b.push_back(da[8*(5-i) +: 8]);
        for (int i = 0; i < 6; i++) b.push_back(8'h0A + 8'(i));
        b.push_back(ty[15:8]); b.push_back(ty[7:0]);
        b.push_back(op[15:8]); b.push_back(op[7:0]);
        b.push_back(q[15:8]);  b.push_back(q[7:0]);
        while (b.size() < len) b.push_back(8'h00);
        exp = rx_fc_en && with_eof && crc && (len >= 18) && (ty == 16'h8808) &&
              (op == 16'h0001) && ((da == GROUP) || (ucast_det_en && da == STATION));
        cur_req = req;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (gaps && i > 0) begin
                rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
                @(negedge clk);
            end
            rx_valid  = 1'b1;
            rx_data   = b[i];
            rx_sof    = (i == 0);
            rx_eof    = with_eof && (i == len - 1);
            rx_crc_ok = crc && (i == len - 1);
            bench_hit = rx_eof && exp;
            bench_q   = int'(q);
        end
        @(posedge clk); #5;
        check_val(req, "pause_seen after frame end", int'(pause_seen), int'(exp));
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0; bench_hit = 1'b0;
    endtask

    task automatic measure_high(output int n);
        n = 0;
        if (tx_inhibit) n = 1;
        while (tx_inhibit) begin
            @(posedge clk); #5;
            if (tx_inhibit) n++;
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int n;
        repeat (4) @(negedge clk);
        @(posedge clk); #5;
        check_val("R10", "reset tx_inhibit", int'(tx_inhibit), 0);
        check_val("R10", "reset pause_seen", int'(pause_seen), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        wait_cycles(3);

        // R2, R5, R9: group address, exact length with a tick every cycle
        send_frame("R2", GROUP, 16'h8808, 16'h0001, 16'h0003, 18, 1'b1, 1'b1, 1'b0);
        check_val("R2", "inhibit after group frame", int'(tx_inhibit), 1);
        cur_req = "R9";
        measure_high(n);
        check_val("R5", "inhibit cycles for 3 quanta", n, 3 * SLOT);
        wait_cycles(4);

        // R3: unicast with detection off, then on
        send_frame("R3", STATION, 16'h8808, 16'h0001, 16'h0002, 20, 1'b1, 1'b1, 1'b1);
        check_val("R3", "unicast ignored when off", int'(tx_inhibit), 0);
        ucast_det_en = 1'b1;
        send_frame("R3", STATION, 16'h8808, 16'h0001, 16'h0001, 18, 1'b1, 1'b1, 1'b0);
        check_val("R3", "unicast accepted when on", int'(tx_inhibit), 1);
        cur_req = "R3";
        measure_high(n);
        ucast_det_en = 1'b0;
        send_frame("R2", GROUP, 16'h8808, 16'h0001, 16'h0001, 18, 1'b1, 1'b1, 1'b0);
        check_val("R2", "group accepted with unicast off", int'(tx_inhibit), 1);
        measure_high(n);

        // R4: wrong type, wrong opcode
        send_frame("R4", GROUP, 16'h8809, 16'h0001, 16'h0002, 24, 1'b1, 1'b1, 1'b0);
        check_val("R4", "wrong type ignored", int'(tx_inhibit), 0);
        send_frame("R4", GROUP, 16'h8808, 16'h0002, 16'h0002, 24, 1'b1, 1'b1, 1'b0);
        check_val("R4", "wrong opcode ignored", int'(tx_inhibit), 0);

        // R6: bad CRC zero-time frame during a pause leaves it running
        send_frame("R6", GROUP, 16'h8808, 16'h0001, 16'h0002, 18, 1'b1, 1'b1, 1'b0);
        wait_cycles(50);
        send_frame("R6", GROUP, 16'h8808, 16'h0001, 16'h0000, 18, 1'b0, 1'b1, 1'b0);
        check_val("R6", "bad CRC keeps inhibit", int'(tx_inhibit), 1);

        // R7: shorter reload restarts the count
        wait_cycles(100);
        send_frame("R7", GROUP, 16'h8808, 16'h0001, 16'h0001, 18, 1'b1, 1'b1, 1'b0);
        measure_high(n);
        check_val("R7", "reload inhibit cycles", n, SLOT);

        // R8: zero time ends a running pause
        send_frame("R8", GROUP, 16'h8808, 16'h0001, 16'h0004, 18, 1'b1, 1'b1, 1'b0);
        wait_cycles(30);
        send_frame("R8", GROUP, 16'h8808, 16'h0001, 16'h0000, 18, 1'b1, 1'b1, 1'b0);
        check_val("R8", "zero quanta clears inhibit", int'(tx_inhibit), 0);

        // R1: clearing enable cancels; frames ignored while disabled
        send_frame("R1", GROUP, 16'h8808, 16'h0001, 16'h0002, 18, 1'b1, 1'b1, 1'b0);
        wait_cycles(10);
        rx_fc_en = 1'b0;
        @(posedge clk); #5;
        check_val("R1", "inhibit low when disabled", int'(tx_inhibit), 0);
        @(negedge clk);
        rx_fc_en = 1'b1;
        @(posedge clk); #5;
        check_val("R1", "cancelled pause not restored", int'(tx_inhibit), 0);
        @(negedge clk);
        rx_fc_en = 1'b0;
        send_frame("R1", GROUP, 16'h8808, 16'h0001, 16'h0002, 18, 1'b1, 1'b1, 1'b0);
        check_val("R1", "no inhibit from frame while disabled", int'(tx_inhibit), 0);
        rx_fc_en = 1'b1;
        wait_cycles(3);

        // R11: short frame, then a restart by start-of-frame mid-frame
        send_frame("R11", GROUP, 16'h8808, 16'h0001, 16'h0002, 17, 1'b1, 1'b1, 1'b0);
        check_val("R11", "17-byte frame ignored", int'(tx_inhibit), 0);
        send_frame("R11", GROUP, 16'h8808, 16'h0001, 16'h0002, 14, 1'b1, 1'b0, 1'b0);
        send_frame("R11", GROUP, 16'h8808, 16'h0001, 16'h0001, 18, 1'b1, 1'b1, 1'b0);
        check_val("R11", "frame after restart accepted", int'(tx_inhibit), 1);
        measure_high(n);
        check_val("R11", "restart frame inhibit cycles", n, SLOT);

        // R5: slower bit tick, checked against the reference each cycle
        tick_div = 3;
        send_frame("R5", GROUP, 16'h8808, 16'h0001, 16'h0002, 40, 1'b1, 1'b1, 1'b1);
        cur_req = "R5";
        measure_high(n);
        check_val("R5", "slow tick inhibit ended", int'(tx_inhibit), 0);
        wait_cycles(5);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule